// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Flag Filtering

This block receives asynchronous serial characters on a bus shared by one master and many listening stations. When the address-flag mode is selected, every character carries one extra bit after its data bits that tells an address character apart from a data character. The receiver decodes the line at all times. While software has reception switched off, it still recognises every frame, but it keeps only characters whose flag marks them as addresses. Software reads the address, compares it against its own station number and switches reception on when the master is talking to it. Afterwards it switches reception off again and waits for the next address.

Bit timing comes from an external enable pulse at sixteen times the baud rate. Received characters go into a four-entry holding queue, together with their flag and a framing-error mark. A ready output tells the host that the queue holds something, and an optional interrupt request follows it.

Top module: `mdrx_rx`

## Requirements
- R1: A frame is a low start bit, then 5, 6, 7 or 8 data bits sent least significant first (`cfg_data_bits` 0 to 3 selects 5 to 8), then one flag bit when `cfg_multidrop` is 1, then one stop bit (`cfg_two_stop`=0) or two stop bits (`cfg_two_stop`=1). Unused upper bits of `rd_data` read as 0.
- R2: A received flag of 1 marks an address character and a flag of 0 marks a data character. The flag of the queue head appears on `rd_addr_flag`. It reads 0 when `cfg_multidrop` is 0.
- R3: The frame decoder runs whether reception is switched on or off, so it keeps character alignment across discarded characters.
- R4: With reception off and `cfg_multidrop`=1, a character with flag 1 is written to the queue and `rx_ready` goes high.
- R5: With reception off, a character with flag 0 is dropped and leaves the queue unchanged. With reception off and `cfg_multidrop`=0, every character is dropped.
- R6: With reception on, every character, address or data, is written to the queue.
- R7: `irq` is high exactly when `irq_en` is 1 and `rx_ready` is 1.
- R8: A low level on the line that has gone high again by the middle of the start bit is treated as a false start and yields no character.
- R9: The queue holds 4 characters, and its oldest entry is always shown on the read port. `rd_en` removes the head. `rd_en` on an empty queue has no effect. A character that arrives while the queue is full is dropped. `rx_ready` is 0 after reset and is low exactly when the queue is empty.
- R10: A stop bit sampled low sets `rd_frame_err` for that character's entry.
- R11: `rx_enable` switches reception on and `rx_disable` switches it off. When both are high in the same cycle, reception ends up off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| rxd | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Pulse: switch reception on |
| rx_disable | input | 1 | Pulse: switch reception off |
| cfg_data_bits | input | 2 | Data bit count minus 5 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_multidrop | input | 1 | 1 adds the address/data flag bit |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Remove the queue head |
| rd_data | output | 8 | Head character |
| rd_addr_flag | output | 1 | Head flag (1 = address) |
| rd_frame_err | output | 1 | Head framing error |
| rx_ready | output | 1 | Queue not empty |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a framing error that does not lose frame alignment. A stop bit held low for its whole length looks like the next start bit. The stimulus therefore holds the faulty stop bit low past its sampling point and releases it before the following start-bit check. This shows that the error is recorded and that the low tail is then rejected as a false start. The filtering on the flag bit is exercised by interleaving data and address characters while reception is off. The queue-full drop is reached by sending five characters back to back without reading.

// File: rtl/mdrx_pkg.sv
`timescale 1ns/1ps
package mdrx_pkg;
  parameter int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_FLAG, ST_STOP
  } mdrx_state_e;

  typedef struct packed {
    logic              ferr;
    logic              flag;
    logic [CHAR_W-1:0] data;
  } mdrx_char_t;
endpackage

// File: rtl/mdrx_frame.sv
`timescale 1ns/1ps
module mdrx_frame
  import mdrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_stop2,
  input  logic       cfg_flag,
  output logic       out_valid,
  output mdrx_char_t out_char
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  logic              rxd_m, rxd_s;
  mdrx_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              flag_q, flag_d, ferr_q, ferr_d, stop2_q, stop2_d;
  logic              done;
  logic              vld_q;
  mdrx_char_t        char_q;

  // line synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  assign last_idx = IDX_W'(CHAR_W - 4) + IDX_W'(cfg_dbits);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    flag_d  = flag_q;
    ferr_d  = ferr_q;
    stop2_d = stop2_q;
    done    = 1'b0;
    if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!rxd_s) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            if (!rxd_s) begin
              state_d = ST_DATA;
              idx_d   = '0;
              data_d  = '0;
              flag_d  = 1'b0;
              ferr_d  = 1'b0;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d          = '0;
            data_d[idx_q]  = rxd_s;
            if (idx_q == last_idx) begin
              state_d = cfg_flag ? ST_FLAG : ST_STOP;
              stop2_d = cfg_stop2;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_FLAG: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            flag_d  = rxd_s;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
            if (!rxd_s) ferr_d = 1'b1;
            if (stop2_q) begin
              stop2_d = 1'b0;
            end else begin
              done    = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      flag_q  <= 1'b0;
      ferr_q  <= 1'b0;
      stop2_q <= 1'b0;
      vld_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      if (tick) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        idx_q   <= idx_d;
        data_q  <= data_d;
        flag_q  <= flag_d;
        ferr_q  <= ferr_d;
        stop2_q <= stop2_d;
      end
      vld_q <= done;
      if (done) char_q <= '{ferr: ferr_d, flag: flag_q, data: data_q};
    end
  end

  assign out_valid = vld_q;
  assign out_char  = char_q;

  // R8: a high line at the start-bit midpoint abandons the frame
  assert_false_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state_q == ST_START && cnt_q == MID_CNT && rxd_s) |=> (state_q == ST_IDLE));
  // R1: each completed frame yields exactly one character strobe
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/mdrx_fifo.sv
`timescale 1ns/1ps
module mdrx_fifo
  import mdrx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  mdrx_char_t                 wdata,
  input  logic                       pop,
  output mdrx_char_t                 rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  mdrx_char_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g] <= '0;
        end else if (do_push && wr_q == PTR_W'(g)) begin
          mem_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = mem_q[rd_q];
  assign count = cnt_q;

  // R9: a character arriving at a full queue is dropped, queue stays full
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == CNT_W'(DEPTH)));
  // R9: reading an empty queue leaves it empty
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/mdrx_rx.sv
`timescale 1ns/1ps
module mdrx_rx
  import mdrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_enable,
  input  logic              rx_disable,
  input  logic [1:0]        cfg_data_bits,
  input  logic              cfg_two_stop,
  input  logic              cfg_multidrop,
  input  logic              irq_en,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_addr_flag,
  output logic              rd_frame_err,
  output logic              rx_ready,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       rst_pipe;
  logic             rst_n_int;
  logic             en_q, en_d;
  logic             frm_valid, accept;
  mdrx_char_t       frm_char, head;
  logic             fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_cnt;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // reception switch, disable has priority
  always_comb begin
    en_d = en_q;
    if (rx_enable)  en_d = 1'b1;
    if (rx_disable) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) en_q <= 1'b0;
    else            en_q <= en_d;
  end

  mdrx_frame #(.OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick16),
    .rxd       (rxd),
    .cfg_dbits (cfg_data_bits),
    .cfg_stop2 (cfg_two_stop),
    .cfg_flag  (cfg_multidrop),
    .out_valid (frm_valid),
    .out_char  (frm_char)
  );

  assign accept = frm_valid && (en_q || (cfg_multidrop && frm_char.flag));

  mdrx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (accept),
    .wdata (frm_char),
    .pop   (rd_en),
    .rdata (head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_cnt)
  );

  assign rd_data      = head.data;
  assign rd_addr_flag = head.flag;
  assign rd_frame_err = head.ferr;
  assign rx_ready     = !fifo_empty;
  assign irq          = irq_en && !fifo_empty;

  // R5: a data character arriving while switched off does not reach the queue
  assert_discard_data_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frm_valid && !en_q && !frm_char.flag && !rd_en) |=> (fifo_cnt == $past(fifo_cnt)));
  // R4: an address character arriving while switched off is queued
  assert_address_kept_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frm_valid && !en_q && cfg_multidrop && frm_char.flag && !fifo_full) |=> !fifo_empty);
endmodule

// File: tb/tb_mdrx_rx.sv
`timescale 1ns/1ps
module tb_mdrx_rx;
  localparam int BIT_CLK = 64;  // 16 ticks, one tick every 4 clocks

  logic       clk = 1'b0;
  logic       rst_n, tick16, rxd, rx_enable, rx_disable;
  logic [1:0] cfg_data_bits;
  logic       cfg_two_stop, cfg_multidrop, irq_en, rd_en;
  logic [7:0] rd_data;
  logic       rd_addr_flag, rd_frame_err, rx_ready, irq;

  int tests = 0, fails = 0;
  bit busy = 1'b1, mon_on = 1'b0, finished = 1'b0, en_m = 1'b0;
  logic [9:0] mq[$];  // {ferr, flag, data}

  always #5 clk = ~clk;

  mdrx_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .rx_enable(rx_enable), .rx_disable(rx_disable),
    .cfg_data_bits(cfg_data_bits), .cfg_two_stop(cfg_two_stop),
    .cfg_multidrop(cfg_multidrop), .irq_en(irq_en), .rd_en(rd_en),
    .rd_data(rd_data), .rd_addr_flag(rd_addr_flag), .rd_frame_err(rd_frame_err),
    .rx_ready(rx_ready), .irq(irq)
  );

  initial begin
    int div = 0;
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      div    = (div + 1) % 4;
      tick16 = (div == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock while no frame is in flight
  always @(posedge clk) begin
    #3;
    if (mon_on && !busy) begin
      chk(rx_ready == (mq.size() != 0), "R9 ready follows queue", rx_ready, mq.size() != 0);
      chk(irq == (irq_en && mq.size() != 0), "R7 irq", irq, irq_en && mq.size() != 0);
      if (mq.size() != 0)
        chk({rd_frame_err, rd_addr_flag, rd_data} == mq[0], "R2 head entry",
            {rd_frame_err, rd_addr_flag, rd_data}, mq[0]);
    end
  end

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit fl, input bit stop_low);
    int nb = 5 + cfg_data_bits;
    int ns = cfg_two_stop ? 2 : 1;
    logic [7:0] m = d & 8'((1 << nb) - 1);
    logic fe = stop_low;
    logic f  = cfg_multidrop ? fl : 1'b0;
    busy = 1'b1;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (cfg_multidrop) drive_bit(fl);
    for (int s = 0; s < ns; s++) begin
      if (stop_low && s == ns - 1) begin
        rxd = 1'b0;
        repeat (48) @(negedge clk);
        rxd = 1'b1;
        repeat (16) @(negedge clk);
      end else begin
        drive_bit(1'b1);
      end
    end
    repeat (BIT_CLK) @(negedge clk);
    if ((en_m || (cfg_multidrop && f)) && mq.size() < 4) mq.push_back({fe, f, m});
    busy = 1'b0;
  endtask

  task automatic read_one();
    rd_en = 1'b1;
    if (mq.size() != 0) void'(mq.pop_front());
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(input bit on, input bit off);
    rx_enable  = on;
    rx_disable = off;
    if (on)  en_m = 1'b1;
    if (off) en_m = 1'b0;
    @(negedge clk);
    rx_enable  = 1'b0;
    rx_disable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_enable = 1'b0; rx_disable = 1'b0; rd_en = 1'b0;
    cfg_data_bits = 2'd3; cfg_two_stop = 1'b0; cfg_multidrop = 1'b1; irq_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_ready == 1'b0, "R9 reset ready", rx_ready, 0);
    chk(irq == 1'b0, "R7 reset irq", irq, 0);
    busy = 1'b0; mon_on = 1'b1;

    // R5 then R3/R4: off, data dropped, following address still decoded
    send(8'h55, 1'b0, 1'b0);
    chk(rx_ready == 1'b0, "R5 data dropped while off", rx_ready, 0);
    send(8'hA3, 1'b1, 1'b0);
    chk(rx_ready == 1'b1, "R4 address queued while off", rx_ready, 1);
    chk(rd_data == 8'hA3 && rd_addr_flag, "R3 alignment kept", {rd_addr_flag, rd_data}, 9'h1A3);
    chk(irq == 1'b1, "R7 irq with ready", irq, 1);
    read_one();

    // R6: on, both kinds kept
    cmd(1'b1, 1'b0);
    send(8'h3C, 1'b0, 1'b0);
    send(8'h11, 1'b1, 1'b0);
    chk(rd_data == 8'h3C && !rd_addr_flag, "R6 data kept while on", {rd_addr_flag, rd_data}, 9'h03C);
    read_one();
    chk(rd_data == 8'h11 && rd_addr_flag, "R2 address flag", {rd_addr_flag, rd_data}, 9'h111);
    read_one();

    // R1: 5 data bits, and 7 data bits with two stops
    cfg_data_bits = 2'd0;
    send(8'hF5, 1'b0, 1'b0);
    chk(rd_data == 8'h15, "R1 five bits", rd_data, 8'h15);
    read_one();
    cfg_data_bits = 2'd2; cfg_two_stop = 1'b1;
    send(8'hDA, 1'b1, 1'b0);
    chk(rd_data == 8'h5A && rd_addr_flag, "R1 seven bits two stops", {rd_addr_flag, rd_data}, 9'h15A);
    read_one();
    cfg_data_bits = 2'd3; cfg_two_stop = 1'b0;

    // R9: overflow drops the fifth, read of empty ignored
    for (int k = 1; k <= 5; k++) send(8'(k), 1'b0, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      chk(rd_data == 8'(k), "R9 order and depth", rd_data, k);
      read_one();
    end
    chk(rx_ready == 1'b0, "R9 fifth dropped, ready cleared", rx_ready, 0);
    read_one();
    send(8'h77, 1'b0, 1'b0);
    chk(rd_data == 8'h77, "R9 empty read had no effect", rd_data, 8'h77);
    read_one();

    // R10: stop bit low
    send(8'hC4, 1'b0, 1'b1);
    chk(rd_frame_err == 1'b1 && rd_data == 8'hC4, "R10 framing error", {rd_frame_err, rd_data}, 9'h1C4);
    read_one();
    chk(rx_ready == 1'b0, "R8 stop tail not taken as start", rx_ready, 0);

    // R8: short low pulse
    busy = 1'b1;
    rxd = 1'b0; repeat (24) @(negedge clk);
    rxd = 1'b1; repeat (2 * BIT_CLK) @(negedge clk);
    busy = 1'b0;
    chk(rx_ready == 1'b0, "R8 false start", rx_ready, 0);
    send(8'h9E, 1'b0, 1'b0);
    chk(rd_data == 8'h9E && !rd_frame_err, "R8 recovered", {rd_frame_err, rd_data}, 9'h09E);
    read_one();

    // R7: interrupt masked
    irq_en = 1'b0;
    send(8'h42, 1'b0, 1'b0);
    chk(rx_ready == 1'b1 && irq == 1'b0, "R7 masked irq", {rx_ready, irq}, 2'b10);
    read_one();
    irq_en = 1'b1;

    // R11: both commands at once leave reception off
    cmd(1'b1, 1'b1);
    send(8'h66, 1'b0, 1'b0);
    chk(rx_ready == 1'b0, "R11 disable wins", rx_ready, 0);

    // R5/R6 without flag bit
    cfg_multidrop = 1'b0;
    send(8'h81, 1'b1, 1'b0);
    chk(rx_ready == 1'b0, "R5 plain mode off drops all", rx_ready, 0);
    cmd(1'b1, 1'b0);
    send(8'h81, 1'b1, 1'b0);
    chk(rd_data == 8'h81 && !rd_addr_flag, "R6 plain mode kept", {rd_addr_flag, rd_data}, 9'h081);
    read_one();

    repeat (8) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule